// File: doc/BRIEF.md
# Host Synchronous Serial Link Controller

This block sits between a host microcontroller and a VPW bus controller and moves 8-bit words over a three-wire synchronous serial link at a nominal 1 MHz. The block always opens a transfer itself. It raises a framing strobe, drives the serial clock, shifts its own word out most significant bit first, and samples the host's word in at the same time. The strobe then drops after a lag time, and a recovery interval follows before the next transfer may start.

The host asks for a transfer on one of two request lines. One line asks for a data-byte transfer and the other asks for a status/control transfer. The two kinds use different lead and lag times. Neighbouring logic supplies the outgoing data word and the outgoing status word on parallel inputs. Each word is captured in the cycle in which its frame opens. The received word is returned on a parallel output together with a one-cycle completion pulse and a kind flag. Outside the frame the serial output is released: its enable is low and its value is held low. All timings are counts of system-clock cycles set by parameters.

Top module: `hsl_link_ctrl`

## Requirements
- R1: After reset, `frame_o`, `sck_o`, `sout_o`, `sout_oe_o` and `done_o` are all low.
- R2: A rising edge on `req_stat_i` starts a status/control transfer that sends `stat_word_i`, and a rising edge on `req_data_i` starts a data transfer that sends `data_word_i`. `rx_stat_o` is 1 for status and 0 for data throughout the frame and in the completion cycle.
- R3: From the rise of `frame_o` to the first rising edge of `sck_o` there are exactly LEAD_STAT cycles for status transfers and LEAD_DATA cycles for data transfers.
- R4: Each frame has exactly 8 rising edges of `sck_o`. Every high phase lasts HALF_CYC cycles, and every low phase between two rising edges lasts HALF_CYC cycles.
- R5: From the last falling edge of `sck_o` to the fall of `frame_o` there are exactly LAG_STAT cycles for status transfers and LAG_DATA cycles for data transfers.
- R6: `sout_o` presents the outgoing word most significant bit first. It is valid before the first rising edge and changes only in the cycle where `sck_o` falls.
- R7: `sin_i` is sampled on each rising edge of `sck_o`, first bit into the most significant position. `done_o` pulses for exactly the one cycle in which `frame_o` falls, and `rx_word_o` then holds the received word.
- R8: `sout_oe_o` is high exactly while `frame_o` is high. Outside the frame, `sout_o` is low.
- R9: After `frame_o` falls it stays low for at least REC_CYC cycles.
- R10: A request edge that arrives during a transfer or during recovery is remembered. It is served as soon as the recovery interval ends.
- R11: When both kinds are pending, the status/control transfer is served first.
- R12: Only rising request edges start transfers. A request held high through a whole transfer and past it starts no further transfer, and its falling edge has no effect.
- R13: `sck_o` is low whenever `frame_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_data_i | input | 1 | Host request for a data-byte transfer (edge triggered) |
| req_stat_i | input | 1 | Host request for a status/control transfer (edge triggered) |
| data_word_i | input | WORD_W | Outgoing data word, captured when its frame opens |
| stat_word_i | input | WORD_W | Outgoing status word, captured when its frame opens |
| sin_i | input | 1 | Serial input from the host |
| sck_o | output | 1 | Serial clock, idle low |
| frame_o | output | 1 | Framing strobe, high during a transfer |
| sout_o | output | 1 | Serial output data |
| sout_oe_o | output | 1 | Serial output enable (low means released) |
| rx_word_o | output | WORD_W | Word received from the host |
| rx_stat_o | output | 1 | Kind of the current or just-finished transfer, 1 = status |
| done_o | output | 1 | One-cycle pulse as the frame closes |

## Verification
The bench aims at the timing seams of a frame. It counts the lead, the high and low phases, and the lag of each kind separately. A design that swapped the two kinds' counts, or was off by one cycle, would show a lead or lag that differs from the parameter. It raises requests while a transfer is in flight, and also raises both kinds at once from idle. A design that dropped latched requests, served them before recovery ended, or favoured data over status would produce frames missing from the scoreboard or out of its order. It holds a request level high for several frame lengths; a level-sensitive design would open extra frames that the scoreboard rejects. Walking patterns such as 0x80 and 0x01 reveal a reversed bit order or a shift on the wrong clock edge.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_LAG,
        ST_REC
    } seq_state_e;

endpackage

// File: rtl/hsl_arb.sv
module hsl_arb (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_data_i,
    input  logic req_stat_i,
    input  logic grant_i,
    output logic pend_any_o,
    output logic pick_stat_o
);

    typedef struct packed {
        logic prev_data;
        logic prev_stat;
        logic pend_data;
        logic pend_stat;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d = arb_q;
        arb_d.prev_data = req_data_i;
        arb_d.prev_stat = req_stat_i;
        // the granted kind is cleared first, so a fresh edge in the same cycle survives
        if (grant_i) begin
            if (arb_q.pend_stat) arb_d.pend_stat = 1'b0;
            else                 arb_d.pend_data = 1'b0;
        end
        if (req_stat_i && !arb_q.prev_stat) arb_d.pend_stat = 1'b1;
        if (req_data_i && !arb_q.prev_data) arb_d.pend_data = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) arb_q <= '0;
        else         arb_q <= arb_d;
    end

    assign pend_any_o  = arb_q.pend_data | arb_q.pend_stat;
    assign pick_stat_o = arb_q.pend_stat;

endmodule

// File: rtl/hsl_seq.sv
module hsl_seq
    import hsl_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int HALF_CYC  = 50,
    parameter int LEAD_STAT = 75,
    parameter int LEAD_DATA = 123,
    parameter int LAG_STAT  = 75,
    parameter int LAG_DATA  = 130,
    parameter int REC_CYC   = 75
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_any_i,
    input  logic pick_stat_i,
    output logic grant_o,
    output logic load_o,
    output logic shift_o,
    output logic sample_o,
    output logic frame_o,
    output logic sck_o,
    output logic kind_stat_o,
    output logic done_o
);

    localparam int CW = $clog2(HALF_CYC + LEAD_STAT + LEAD_DATA + LAG_STAT + LAG_DATA + REC_CYC + 1);
    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] HALF_LD   = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] LEAD_S_LD = CW'(LEAD_STAT - 1);
    localparam logic [CW-1:0] LEAD_D_LD = CW'(LEAD_DATA - 1);
    localparam logic [CW-1:0] LAG_S_LD  = CW'(LAG_STAT - 1);
    localparam logic [CW-1:0] LAG_D_LD  = CW'(LAG_DATA - 1);
    localparam logic [CW-1:0] REC_LD    = CW'(REC_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bits;
        logic          frame;
        logic          sck;
        logic          stat;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic can_start;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        grant_o    = 1'b0;
        load_o     = 1'b0;
        shift_o    = 1'b0;
        sample_o   = 1'b0;
        can_start  = (seq_q.state == ST_IDLE) ||
                     ((seq_q.state == ST_REC) && (seq_q.cnt == '0));

        unique case (seq_q.state)
            ST_LEAD, ST_LOW: begin
                if (seq_q.cnt == '0) begin
                    seq_d.sck   = 1'b1;
                    sample_o    = 1'b1;
                    seq_d.state = ST_HIGH;
                    seq_d.cnt   = HALF_LD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_HIGH: begin
                if (seq_q.cnt == '0) begin
                    seq_d.sck = 1'b0;
                    if (seq_q.bits == LAST_BIT) begin
                        seq_d.state = ST_LAG;
                        seq_d.cnt   = seq_q.stat ? LAG_S_LD : LAG_D_LD;
                    end else begin
                        seq_d.state = ST_LOW;
                        seq_d.cnt   = HALF_LD;
                        seq_d.bits  = seq_q.bits + 1'b1;
                        shift_o     = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_LAG: begin
                if (seq_q.cnt == '0) begin
                    seq_d.frame = 1'b0;
                    seq_d.done  = 1'b1;
                    seq_d.state = ST_REC;
                    seq_d.cnt   = REC_LD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_REC: begin
                if (seq_q.cnt != '0) seq_d.cnt = seq_q.cnt - 1'b1;
            end
            default: ;
        endcase

        if (can_start) begin
            if (pend_any_i) begin
                grant_o     = 1'b1;
                load_o      = 1'b1;
                seq_d.stat  = pick_stat_i;
                seq_d.frame = 1'b1;
                seq_d.bits  = '0;
                seq_d.state = ST_LEAD;
                seq_d.cnt   = pick_stat_i ? LEAD_S_LD : LEAD_D_LD;
            end else begin
                seq_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign frame_o     = seq_q.frame;
    assign sck_o       = seq_q.sck;
    assign kind_stat_o = seq_q.stat;
    assign done_o      = seq_q.done;

endmodule

// File: rtl/hsl_shift.sv
module hsl_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    input  logic              sample_i,
    input  logic              sin_i,
    output logic              bit_o,
    output logic [WORD_W-1:0] rx_o
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            shf_d.tx = word_i;
            shf_d.rx = '0;
        end else if (shift_i) begin
            shf_d.tx = {shf_q.tx[WORD_W-2:0], 1'b0};
        end
        if (sample_i) shf_d.rx = {shf_q.rx[WORD_W-2:0], sin_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) shf_q <= '0;
        else         shf_q <= shf_d;
    end

    assign bit_o = shf_q.tx[WORD_W-1];
    assign rx_o  = shf_q.rx;

endmodule

// File: rtl/hsl_link_ctrl.sv
module hsl_link_ctrl #(
    parameter int WORD_W    = 8,
    parameter int HALF_CYC  = 50,
    parameter int LEAD_STAT = 75,
    parameter int LEAD_DATA = 123,
    parameter int LAG_STAT  = 75,
    parameter int LAG_DATA  = 130,
    parameter int REC_CYC   = 75
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_data_i,
    input  logic              req_stat_i,
    input  logic [WORD_W-1:0] data_word_i,
    input  logic [WORD_W-1:0] stat_word_i,
    input  logic              sin_i,
    output logic              sck_o,
    output logic              frame_o,
    output logic              sout_o,
    output logic              sout_oe_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_stat_o,
    output logic              done_o
);

    logic pend_any, pick_stat, grant;
    logic load, shift, sample, tx_bit;
    logic frame_int;

    hsl_arb u_arb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_data_i  (req_data_i),
        .req_stat_i  (req_stat_i),
        .grant_i     (grant),
        .pend_any_o  (pend_any),
        .pick_stat_o (pick_stat)
    );

    hsl_seq #(
        .WORD_W    (WORD_W),
        .HALF_CYC  (HALF_CYC),
        .LEAD_STAT (LEAD_STAT),
        .LEAD_DATA (LEAD_DATA),
        .LAG_STAT  (LAG_STAT),
        .LAG_DATA  (LAG_DATA),
        .REC_CYC   (REC_CYC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pend_any_i  (pend_any),
        .pick_stat_i (pick_stat),
        .grant_o     (grant),
        .load_o      (load),
        .shift_o     (shift),
        .sample_o    (sample),
        .frame_o     (frame_int),
        .sck_o       (sck_o),
        .kind_stat_o (rx_stat_o),
        .done_o      (done_o)
    );

    hsl_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .word_i   (pick_stat ? stat_word_i : data_word_i),
        .shift_i  (shift),
        .sample_i (sample),
        .sin_i    (sin_i),
        .bit_o    (tx_bit),
        .rx_o     (rx_word_o)
    );

    assign frame_o   = frame_int;
    assign sout_oe_o = frame_int;
    assign sout_o    = frame_int & tx_bit;

endmodule

// File: rtl/hsl_link_chk.sv
module hsl_link_chk #(
    parameter int HALF_CYC = 50,
    parameter int REC_CYC  = 75
) (
    input logic clk_i,
    input logic rst_ni,
    input logic frame_o,
    input logic sck_o,
    input logic sout_o,
    input logic done_o
);

    localparam int HCW = $clog2(HALF_CYC + 2);
    localparam int GCW = $clog2(REC_CYC + 2);
    localparam logic [HCW-1:0] HI_SAT  = HCW'(HALF_CYC + 1);
    localparam logic [HCW-1:0] HI_EXP  = HCW'(HALF_CYC);
    localparam logic [GCW-1:0] GAP_SAT = GCW'(REC_CYC);

    logic [HCW-1:0] hi_cnt_q;
    logic [GCW-1:0] gap_cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hi_cnt_q  <= '0;
            gap_cnt_q <= GAP_SAT;
        end else begin
            if (!sck_o)               hi_cnt_q <= '0;
            else if (hi_cnt_q != HI_SAT) hi_cnt_q <= hi_cnt_q + 1'b1;
            if (frame_o)                 gap_cnt_q <= '0;
            else if (gap_cnt_q != GAP_SAT) gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

    p_sck_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_o |-> !sck_o);

    p_sout_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_o && $past(frame_o) && !$fell(sck_o)) |-> $stable(sout_o));

    p_high_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sck_o) |-> (hi_cnt_q == HI_EXP));

    p_recovery_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frame_o) |-> (gap_cnt_q >= GAP_SAT));

    p_done_at_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $fell(frame_o));

    p_fall_gives_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(frame_o) |-> done_o);

endmodule

bind hsl_link_ctrl hsl_link_chk #(
    .HALF_CYC (HALF_CYC),
    .REC_CYC  (REC_CYC)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_o (frame_o),
    .sck_o   (sck_o),
    .sout_o  (sout_o),
    .done_o  (done_o)
);

// File: tb/hsl_link_ctrl_tb.sv
module hsl_link_ctrl_tb;

    localparam int HALF = 50;
    localparam int LDS  = 75;
    localparam int LDD  = 123;
    localparam int LGS  = 75;
    localparam int LGD  = 130;
    localparam int REC  = 75;

    typedef struct {
        logic       stat;
        logic [7:0] tx;
        logic [7:0] hw;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_data = 1'b0, req_stat = 1'b0;
    logic [7:0] data_word = '0, stat_word = '0;
    logic sin = 1'b0;
    logic sck, frame, sout, sout_oe, rx_stat, done;
    logic [7:0] rx_word;

    always #5 clk = ~clk;

    hsl_link_ctrl #(
        .WORD_W(8), .HALF_CYC(HALF), .LEAD_STAT(LDS), .LEAD_DATA(LDD),
        .LAG_STAT(LGS), .LAG_DATA(LGD), .REC_CYC(REC)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_data_i(req_data), .req_stat_i(req_stat),
        .data_word_i(data_word), .stat_word_i(stat_word), .sin_i(sin),
        .sck_o(sck), .frame_o(frame), .sout_o(sout), .sout_oe_o(sout_oe),
        .rx_word_o(rx_word), .rx_stat_o(rx_stat), .done_o(done)
    );

    int checks = 0, fails = 0;
    int outstanding = 0, served = 0, expected_total = 0;
    int last_gap = 0;
    bit finished = 0;
    item_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor, sampling on the falling clock edge
    item_t cur;
    logic pf = 0, ps = 0;
    int lead_n, lag_n, hi_n, lo_n, rises, gap_n = 0, hidx;
    bit seen_fall = 0, bad_phase, bad_oe, bad_kind;
    logic [7:0] txbits;

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame && !pf) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R12", "frame opened with no request expected", 1, 0);
                    cur = '{stat: 1'b0, tx: 8'h00, hw: 8'h00};
                end else begin
                    cur = exp_q.pop_front();
                end
                chk(rx_stat == cur.stat, "R2/R11", "transfer kind", rx_stat, cur.stat);
                if (seen_fall) chk(gap_n >= REC, "R9", "recovery length", gap_n, REC);
                last_gap = gap_n;
                lead_n = 0; lag_n = 0; hi_n = 0; lo_n = 0; rises = 0;
                bad_phase = 0; bad_oe = 0; bad_kind = 0; txbits = '0;
                sin = cur.hw[7];
                hidx = 6;
            end
            if (frame) begin
                if (!sout_oe) bad_oe = 1;
                if (rx_stat != cur.stat) bad_kind = 1;
                if (sck && !ps) begin
                    rises++;
                    txbits = {txbits[6:0], sout};
                    if (rises == 1)
                        chk(lead_n == (cur.stat ? LDS : LDD), "R3", "lead cycles",
                            lead_n, cur.stat ? LDS : LDD);
                    else if (lo_n != HALF) bad_phase = 1;
                    hi_n = 0;
                end
                if (!sck && ps) begin
                    if (hi_n != HALF) bad_phase = 1;
                    lo_n = 0;
                    lag_n = 0;
                    if (hidx >= 0) sin = cur.hw[hidx];
                    hidx--;
                end
                if (sck) hi_n++;
                else begin
                    lo_n++;
                    lag_n++;
                    if (rises == 0) lead_n++;
                end
            end else begin
                if (sout_oe || sout) chk(0, "R8", "output released outside frame", sout_oe, 0);
                if (sck) chk(0, "R13", "clock low outside frame", sck, 0);
                if (pf) begin
                    served++;
                    outstanding--;
                    seen_fall = 1;
                    gap_n = 0;
                    chk(done == 1'b1, "R7", "done at frame close", done, 1);
                    chk(rx_word == cur.hw, "R7", "received word", rx_word, cur.hw);
                    chk(rx_stat == cur.stat && !bad_kind, "R2", "kind flag held", rx_stat, cur.stat);
                    chk(txbits == cur.tx, "R6", "sent word msb first", txbits, cur.tx);
                    chk(rises == 8, "R4", "rising edges per frame", rises, 8);
                    chk(!bad_phase, "R4", "half period lengths", bad_phase, 0);
                    chk(lag_n == (cur.stat ? LGS : LGD), "R5", "lag cycles",
                        lag_n, cur.stat ? LGS : LGD);
                    chk(!bad_oe, "R8", "output enabled inside frame", bad_oe, 0);
                end else if (done) begin
                    chk(0, "R7", "done outside frame close", done, 0);
                end
                gap_n++;
            end
            pf = frame;
            ps = sck;
        end
    end

    task automatic expect_xfer(input logic stat, input logic [7:0] tx, input logic [7:0] hw);
        item_t it;
        it.stat = stat; it.tx = tx; it.hw = hw;
        exp_q.push_back(it);
        outstanding++;
        expected_total++;
    endtask

    task automatic pulse(input logic stat);
        @(negedge clk);
        if (stat) req_stat = 1'b1; else req_data = 1'b1;
        repeat (3) @(negedge clk);
        if (stat) req_stat = 1'b0; else req_data = 1'b0;
    endtask

    task automatic wait_idle();
        while (outstanding != 0) @(negedge clk);
        repeat (REC + 10) @(negedge clk);
    endtask

    task automatic single(input logic stat, input logic [7:0] tx, input logic [7:0] hw);
        if (stat) stat_word = tx; else data_word = tx;
        expect_xfer(stat, tx, hw);
        pulse(stat);
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(frame == 0 && sck == 0 && sout == 0 && sout_oe == 0 && done == 0,
            "R1", "outputs in reset", {frame, sck, sout, sout_oe, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(frame == 0 && sck == 0 && sout_oe == 0 && done == 0,
            "R1", "outputs after reset", {frame, sck, sout_oe, done}, 0);

        // R2..R8 with several word patterns
        single(1'b0, 8'hA5, 8'h3C);
        single(1'b1, 8'h5A, 8'hC3);
        single(1'b0, 8'h00, 8'hFF);
        single(1'b1, 8'hFF, 8'h00);
        single(1'b0, 8'h80, 8'h01);
        single(1'b1, 8'h01, 8'h80);

        // R10: second data request during an active transfer
        data_word = 8'h96;
        expect_xfer(1'b0, 8'h96, 8'h69);
        expect_xfer(1'b0, 8'h96, 8'h69);
        pulse(1'b0);
        wait (frame == 1'b1);
        repeat (300) @(negedge clk);
        pulse(1'b0);
        wait_idle();
        chk(last_gap == REC, "R10", "latched request served right after recovery", last_gap, REC);

        // R11: both kinds pending during a transfer, status wins
        data_word = 8'h11;
        stat_word = 8'hEE;
        expect_xfer(1'b0, 8'h11, 8'h4B);
        expect_xfer(1'b1, 8'hEE, 8'hB4);
        expect_xfer(1'b0, 8'h11, 8'h4B);
        pulse(1'b0);
        wait (frame == 1'b1);
        repeat (200) @(negedge clk);
        pulse(1'b0);
        repeat (5) @(negedge clk);
        pulse(1'b1);
        wait_idle();

        // R11: both kinds raised in the same cycle from idle
        data_word = 8'h3F;
        stat_word = 8'hC0;
        expect_xfer(1'b1, 8'hC0, 8'h55);
        expect_xfer(1'b0, 8'h3F, 8'hAA);
        @(negedge clk);
        req_data = 1'b1;
        req_stat = 1'b1;
        repeat (3) @(negedge clk);
        req_data = 1'b0;
        req_stat = 1'b0;
        wait_idle();

        // R12: a held level starts one transfer only
        data_word = 8'h72;
        expect_xfer(1'b0, 8'h72, 8'h27);
        @(negedge clk);
        req_data = 1'b1;
        repeat (3000) @(negedge clk);
        chk(frame == 0 && outstanding == 0, "R12", "no extra frame while held", frame, 0);
        req_data = 1'b0;
        repeat (2000) @(negedge clk);
        chk(frame == 0 && exp_q.size() == 0, "R12", "falling edge opens nothing", frame, 0);

        chk(served == expected_total, "R2", "transfers served", served, expected_total);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", served, expected_total);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule